// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This controller decides what keeps running while a small processor system sleeps. A one-cycle sleep instruction pulse, gated by a sleep-enable bit, moves it from Active into one of three sleep states. A two-bit mode field picks the state: Idle, Standby or Power-Down. While asleep, the controller halts the CPU and drives clock enables for the peripherals and for the clock sources. Each peripheral and each gateable clock source provides a run-in-standby bit, and Standby honours those bits.

The controller also sorts the incoming interrupt requests. For each request it decides whether that request may end the current sleep state, and it only acts on the ones that may. Several inputs shape that decision: a low-leakage flag, a pin-asynchronous qualifier and the filter and edge settings of the logic-cell path. A qualified request returns the controller to Active on the next clock edge, and at that edge every enable comes back. A sleep request does not enter sleep while a request that would qualify in the target state is already present.

Top module: `sleep_ctrl`

## Requirements
- R1: After reset, `sleep_state` is 0 (Active), `cpu_halt` is 0 and every clock enable output is 1.
- R2: In Active, a cycle with `sleep_pulse`=1 and `sleep_en`=1 moves `sleep_state` on the next edge to the target state. `mode` 0 selects Idle (state 1), 1 selects Standby (state 2) and 2 selects Power-Down (state 3). A pulse with `sleep_en`=0 has no effect.
- R3: In Idle, `cpu_halt` is 1 and every clock enable output stays 1.
- R4: In Standby, each bit of `per_clk_en` equals its `per_stby` bit. `main_clk_en`, `logic_clk_en` and `rtc_cnt_en` follow `main_stby`, `logic_stby` and `rtc_stby`. `rtc_pit_en` is 1 and `tmr_clk_en` is 0.
- R5: In Power-Down, `per_clk_en`, `main_clk_en`, `logic_clk_en`, `tmr_clk_en` and `rtc_cnt_en` are 0 whatever the run-in-standby bits say, and `rtc_pit_en` is 1.
- R6: `wdt_osc_en` and `bod_osc_en` are 1 in every state.
- R7: A qualified wake request in a sleep state sets `wake` to 1 in that cycle and returns `sleep_state` to 0 on the next edge, with all enables restored.
- R8: In Idle, any request wakes the device: pin, bod, rtc counter, rtc periodic, two-wire, logic, any `grp_irq` bit or any `oth_irq` bit.
- R9: In Standby, `oth_irq` is ignored and `rtc_cnt_irq` wakes only when `rtc_stby`=1. The pin, bod, rtc periodic, two-wire, logic and `grp_irq` requests all wake.
- R10: In Power-Down, only these requests wake the device:
  - bod and rtc periodic, always;
  - the pin request, only with `pin_async`=1;
  - the two-wire request, only with `low_leak`=0;
  - the logic request, only with `low_leak`=0, `logic_filt`=0 and `logic_edge`=0.
  All other requests are ignored.
- R11: `mode`=3 is treated as Idle.
- R12: A sleep request is ignored, and the state stays Active, when a request is present in the same cycle that would qualify in the target state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_pulse | input | 1 | One-cycle sleep instruction |
| sleep_en | input | 1 | Allows the sleep pulse to take effect |
| mode | input | 2 | Target sleep mode |
| low_leak | input | 1 | Low-leakage flag for Power-Down |
| per_stby | input | NPER | Run-in-standby bit for each peripheral |
| main_stby | input | 1 | Run-in-standby bit for the main clock |
| logic_stby | input | 1 | Run-in-standby bit for the logic-cell clock |
| rtc_stby | input | 1 | Run-in-standby bit for the rtc counter |
| pin_irq | input | 1 | Port pin-change request |
| pin_async | input | 1 | The requesting pin is fully asynchronous |
| bod_irq | input | 1 | Brown-out level-monitor request |
| rtc_cnt_irq | input | 1 | RTC counter request |
| rtc_pit_irq | input | 1 | RTC periodic request |
| twi_irq | input | 1 | Two-wire address-match request |
| logic_irq | input | 1 | Logic-cell request |
| logic_filt | input | 2 | Filter select of the logic path |
| logic_edge | input | 2 | Edge-detect setting of the logic path |
| grp_irq | input | NGRP | Timer, comparator, ADC, touch and zero-cross requests |
| oth_irq | input | NOTH | All remaining requests |
| sleep_state | output | 2 | 0 Active, 1 Idle, 2 Standby, 3 Power-Down |
| cpu_halt | output | 1 | CPU halted |
| wake | output | 1 | Qualified wake request in this cycle |
| per_clk_en | output | NPER | Peripheral clock enables |
| main_clk_en | output | 1 | Main clock source enable |
| logic_clk_en | output | 1 | Logic-cell clock enable |
| tmr_clk_en | output | 1 | Dedicated timer clock enable |
| rtc_cnt_en | output | 1 | RTC counter function enable |
| rtc_pit_en | output | 1 | RTC periodic function enable |
| wdt_osc_en | output | 1 | Watchdog oscillator enable |
| bod_osc_en | output | 1 | Brown-out oscillator enable |

## Verification
The only state is the sleep-state register, and every enable is decoded from it without further delay. A wrong state therefore shows up at once, in the cycle after the faulty edge: `sleep_state` reads wrong, `cpu_halt` is wrong, or the Standby and Power-Down enable pattern is wrong. A wrong qualification has a different signature. The device either leaves sleep one edge too early or never leaves it. The bench watches for both outcomes at the state port by driving a request that should be ignored and then one that should be honoured.

// File: rtl/sleep_ctrl.sv
module sleep_ctrl #(
  parameter int NPER = 4,
  parameter int NGRP = 5,
  parameter int NOTH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_pulse,
  input  logic            sleep_en,
  input  logic [1:0]      mode,
  input  logic            low_leak,
  input  logic [NPER-1:0] per_stby,
  input  logic            main_stby,
  input  logic            logic_stby,
  input  logic            rtc_stby,
  input  logic            pin_irq,
  input  logic            pin_async,
  input  logic            bod_irq,
  input  logic            rtc_cnt_irq,
  input  logic            rtc_pit_irq,
  input  logic            twi_irq,
  input  logic            logic_irq,
  input  logic [1:0]      logic_filt,
  input  logic [1:0]      logic_edge,
  input  logic [NGRP-1:0] grp_irq,
  input  logic [NOTH-1:0] oth_irq,
  output logic [1:0]      sleep_state,
  output logic            cpu_halt,
  output logic            wake,
  output logic [NPER-1:0] per_clk_en,
  output logic            main_clk_en,
  output logic            logic_clk_en,
  output logic            tmr_clk_en,
  output logic            rtc_cnt_en,
  output logic            rtc_pit_en,
  output logic            wdt_osc_en,
  output logic            bod_osc_en
);
  localparam logic [1:0] ST_ACT = 2'd0, ST_IDLE = 2'd1, ST_STBY = 2'd2, ST_PD = 2'd3;

  logic [1:0] st, st_nx, tgt;
  logic q_idle, q_stby, q_pd, q_tgt, q_cur, lut_async, go;

  assign lut_async = (logic_filt == 2'd0) && (logic_edge == 2'd0);

  assign q_idle = pin_irq | bod_irq | rtc_cnt_irq | rtc_pit_irq | twi_irq | logic_irq
                | (|grp_irq) | (|oth_irq);
  assign q_stby = pin_irq | bod_irq | rtc_pit_irq | (rtc_cnt_irq & rtc_stby) | twi_irq
                | logic_irq | (|grp_irq);
  assign q_pd   = bod_irq | rtc_pit_irq | (pin_irq & pin_async)
                | (~low_leak & (twi_irq | (logic_irq & lut_async)));

  assign tgt = (mode == 2'd1) ? ST_STBY : (mode == 2'd2) ? ST_PD : ST_IDLE;

  always_comb begin
    case (tgt)
      ST_STBY: q_tgt = q_stby;
      ST_PD:   q_tgt = q_pd;
      default: q_tgt = q_idle;
    endcase
    case (st)
      ST_IDLE: q_cur = q_idle;
      ST_STBY: q_cur = q_stby;
      ST_PD:   q_cur = q_pd;
      default: q_cur = 1'b0;
    endcase
  end

  assign wake = (st != ST_ACT) && q_cur;
  assign go   = (st == ST_ACT) && sleep_pulse && sleep_en && !q_tgt;

  always_comb begin
    st_nx = st;
    if (go)        st_nx = tgt;
    else if (wake) st_nx = ST_ACT;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= ST_ACT;
    else        st <= st_nx;

  assign sleep_state  = st;
  assign cpu_halt     = (st != ST_ACT);
  assign per_clk_en   = (st == ST_PD) ? '0 : (st == ST_STBY) ? per_stby : '1;
  assign main_clk_en  = (st == ST_PD) ? 1'b0 : (st == ST_STBY) ? main_stby : 1'b1;
  assign logic_clk_en = (st == ST_PD) ? 1'b0 : (st == ST_STBY) ? logic_stby : 1'b1;
  assign rtc_cnt_en   = (st == ST_PD) ? 1'b0 : (st == ST_STBY) ? rtc_stby : 1'b1;
  assign tmr_clk_en   = (st == ST_ACT) || (st == ST_IDLE);
  assign rtc_pit_en   = 1'b1;
  assign wdt_osc_en   = 1'b1;
  assign bod_osc_en   = 1'b1;

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state == ST_ACT && sleep_pulse && sleep_en && !wake && mode == 2'd2 && !q_pd)
    |=> sleep_state == ST_PD); // R2
  AST_NO_SLEEP_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state == ST_ACT && !sleep_en) |=> sleep_state == ST_ACT); // R2
  AST_WAKE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (sleep_state == ST_ACT && !cpu_halt && main_clk_en && (&per_clk_en))); // R7
  AST_PD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state == ST_PD) |-> (per_clk_en == '0 && !main_clk_en && !tmr_clk_en)); // R5
  AST_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state == ST_ACT && sleep_pulse && sleep_en && mode != 2'd1 && mode != 2'd2
     && (|oth_irq)) |=> sleep_state == ST_ACT); // R12
  AST_LEAK_BLOCKS_TWI: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state == ST_PD && low_leak && twi_irq && !bod_irq && !rtc_pit_irq
     && !(pin_irq && pin_async)) |=> sleep_state == ST_PD); // R10
endmodule

// File: tb/sleep_ctrl_test.sv
`timescale 1ns/1ps
module sleep_ctrl_test;
  localparam int NPER = 4, NGRP = 5, NOTH = 3;

  logic clk = 0, rst_n = 0;
  logic sp = 0, se = 0, low_leak = 0, main_stby = 0, logic_stby = 0, rtc_stby = 0;
  logic [1:0] mode = 0, lfilt = 0, ledge = 0;
  logic [NPER-1:0] per_stby = 0;
  logic pin = 0, pin_async = 0, bod = 0, rcnt = 0, rpit = 0, twi = 0, lgc = 0;
  logic [NGRP-1:0] grp = 0;
  logic [NOTH-1:0] oth = 0;

  logic [1:0] sleep_state;
  logic cpu_halt, wake, main_clk_en, logic_clk_en, tmr_clk_en, rtc_cnt_en, rtc_pit_en;
  logic wdt_osc_en, bod_osc_en;
  logic [NPER-1:0] per_clk_en;

  always #2 clk = ~clk;

  sleep_ctrl #(.NPER(NPER), .NGRP(NGRP), .NOTH(NOTH)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_pulse(sp), .sleep_en(se), .mode(mode),
    .low_leak(low_leak), .per_stby(per_stby), .main_stby(main_stby),
    .logic_stby(logic_stby), .rtc_stby(rtc_stby), .pin_irq(pin), .pin_async(pin_async),
    .bod_irq(bod), .rtc_cnt_irq(rcnt), .rtc_pit_irq(rpit), .twi_irq(twi),
    .logic_irq(lgc), .logic_filt(lfilt), .logic_edge(ledge), .grp_irq(grp),
    .oth_irq(oth), .sleep_state(sleep_state), .cpu_halt(cpu_halt), .wake(wake),
    .per_clk_en(per_clk_en), .main_clk_en(main_clk_en), .logic_clk_en(logic_clk_en),
    .tmr_clk_en(tmr_clk_en), .rtc_cnt_en(rtc_cnt_en), .rtc_pit_en(rtc_pit_en),
    .wdt_osc_en(wdt_osc_en), .bod_osc_en(bod_osc_en));

  typedef struct { string tag; logic [13:0] v; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  logic [1:0] ms = 0;
  bit done = 0;

  function automatic logic [13:0] expv(logic [1:0] s);
    case (s)
      2'd2:    return {s, 1'b1, per_stby, main_stby, logic_stby, 1'b0, rtc_stby, 3'b111};
      2'd3:    return {s, 1'b1, {NPER{1'b0}}, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111};
      default: return {s, s != 2'd0, {NPER{1'b1}}, 7'b1111111};
    endcase
  endfunction

  function automatic bit qual(logic [1:0] s);
    case (s)
      2'd1: return pin || bod || rcnt || rpit || twi || lgc || grp != 0 || oth != 0;
      2'd2: return pin || bod || rpit || (rcnt && rtc_stby) || twi || lgc || grp != 0;
      2'd3: return bod || rpit || (pin && pin_async) ||
                   (!low_leak && (twi || (lgc && lfilt == 0 && ledge == 0)));
      default: return 0;
    endcase
  endfunction

  task automatic step(string tag);
    logic [1:0] nx, tg;
    nx = ms;
    tg = (mode == 2'd1) ? 2'd2 : (mode == 2'd2) ? 2'd3 : 2'd1;
    if (ms == 0) begin
      if (sp && se && !qual(tg)) nx = tg;
    end else if (qual(ms)) nx = 0;
    @(posedge clk);
    ms = nx;
    #1;
    q.push_back('{tag, expv(ms)});
    @(negedge clk);
    #1;
    sp = 0; pin = 0; bod = 0; rcnt = 0; rpit = 0; twi = 0; lgc = 0; grp = 0; oth = 0;
  endtask

  task automatic sleep(logic [1:0] m, bit en, string tag);
    mode = m; sp = 1; se = en;
    step(tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [13:0] got;
      it = q.pop_front();
      got = {sleep_state, cpu_halt, per_clk_en, main_clk_en, logic_clk_en, tmr_clk_en,
             rtc_cnt_en, rtc_pit_en, wdt_osc_en, bod_osc_en};
      checks++;
      if (got !== it.v) begin
        errors++;
        $display("FAIL %s: got %b expected %b", it.tag, got, it.v);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    step("R1 reset state");
    step("R1 reset hold");

    sleep(2'd0, 1'b0, "R2 sleep_en low ignored");
    sleep(2'd0, 1'b1, "R2 R3 enter idle");
    step("R3 R6 idle steady");
    oth = 3'b100; step("R8 R7 idle wake by other");
    step("R7 active after idle");

    per_stby = 4'b1010; main_stby = 1; logic_stby = 0; rtc_stby = 0;
    sleep(2'd1, 1'b1, "R2 R4 enter standby");
    oth = 3'b001; step("R9 other ignored in standby");
    rcnt = 1; step("R9 rtc counter ignored without run bit");
    grp = 5'b00100; step("R9 R7 group wakes standby");
    per_stby = 4'b0101; main_stby = 0; logic_stby = 1; rtc_stby = 1;
    sleep(2'd1, 1'b1, "R4 standby other pattern");
    rcnt = 1; step("R9 rtc counter wakes with run bit");

    per_stby = 4'b1111; main_stby = 1; logic_stby = 1; rtc_stby = 1;
    sleep(2'd2, 1'b1, "R5 R6 enter power-down");
    pin = 1; pin_async = 0; step("R10 sync pin ignored");
    grp = 5'b11111; oth = 3'b111; rcnt = 1; step("R10 group, other, counter ignored");
    pin = 1; pin_async = 1; step("R10 async pin wakes");

    low_leak = 1;
    sleep(2'd2, 1'b1, "R5 power-down low leak");
    twi = 1; step("R10 twi blocked by low leak");
    lgc = 1; step("R10 logic blocked by low leak");
    bod = 1; step("R10 bod wakes under low leak");

    low_leak = 0; lfilt = 2'd1;
    sleep(2'd2, 1'b1, "R5 power-down again");
    lgc = 1; step("R10 filtered logic ignored");
    lfilt = 0; ledge = 2'd2; lgc = 1; step("R10 edge logic ignored");
    ledge = 0; lgc = 1; step("R10 async logic wakes");
    sleep(2'd2, 1'b1, "R5 power-down for twi");
    twi = 1; step("R10 twi wakes without low leak");
    sleep(2'd2, 1'b1, "R5 power-down for pit");
    rpit = 1; step("R10 periodic wakes");

    sleep(2'd3, 1'b1, "R11 undefined mode is idle");
    lgc = 1; step("R8 logic wakes idle");

    oth = 3'b010; sleep(2'd0, 1'b1, "R12 pending other blocks idle");
    grp = 5'b00001; sleep(2'd1, 1'b1, "R12 pending group blocks standby");
    oth = 3'b001; sleep(2'd2, 1'b1, "R12 unqualified request allows power-down");
    bod = 1; step("R7 bod wakes power-down");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule